// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block is the power manager of a small microcontroller core. When the core issues a sleep strobe while its sleep-enable bit is set, the block reads a 3-bit mode select and moves into one of four low-power modes. Each mode halts a different set of clock domains: CPU, I/O, non-volatile memory and ADC. The block also drives the oscillator run enable. Each mode accepts its own set of wake sources. On wake-up the core returns to the active mode and receives a one-cycle acknowledge.

Waking from the deepest mode (oscillator stopped) goes through an oscillator start-up phase. That phase lasts a programmable number of cycles. Waking from standby keeps the oscillator running and skips this phase.

A power reduction register holds one bit per peripheral. Setting a bit gates that peripheral's clock, which freezes its state. It also blocks bus access to the peripheral: reads return zero and writes are dropped. Clearing the bit lets the peripheral resume from where it stopped. All pins are plain control and status signals, and there is no streaming interface.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the block is active. All four domain clock enables and `osc_run` are 1, `mode_status` is 0, and the power reduction register is all zeros. `adc_start` and `wake_ack` are 0.
- R2: The block acts on a sleep strobe only while it is active, `sleep_en` is 1 and `mode_sel` is one of 000, 001, 010 or 100. Any other mode code, or `sleep_en` at 0, leaves the block active. The new mode shows from the clock edge that samples the strobe.
- R3: Mode select 000 enters idle (`mode_status` 1). The CPU and NVM enables are 0; the I/O, ADC and oscillator enables stay 1.
- R4: Mode select 001 enters ADC noise reduction (`mode_status` 2). The CPU, I/O and NVM enables are 0; the ADC and oscillator enables stay 1.
- R5: Entering idle or ADC noise reduction while `adc_enabled` is 1 raises `adc_start` for exactly the first cycle of that mode. Otherwise `adc_start` stays 0, including on entry to power-down or standby.
- R6: Mode select 010 enters power-down (`mode_status` 3), where every enable including `osc_run` is 0. Only `wake_int0`, `wake_pcint` and `wake_wdt` end this mode; `wake_other` is ignored.
- R7: Mode select 100 enters standby (`mode_status` 4). It behaves like power-down except that `osc_run` stays 1. A permitted wake returns the block to active at the next clock edge.
- R8: A wake from power-down enters an oscillator start-up phase (`mode_status` 5) for `startup_cycles`+1 cycles. During this phase `osc_run` is 1 and all domain enables are 0. The block then returns to active; this holds for `startup_cycles` of 0 and of its maximum value.
- R9: Idle and ADC noise reduction wake on any of `wake_int0`, `wake_pcint`, `wake_wdt` or `wake_other`. `wake_ack` is 1 for exactly the first active cycle after any sleep mode.
- R10: `prr_wr` loads the power reduction register from `prr_wdata`; bit i controls peripheral i. While bit i is 1, `periph_clk_en[i]` is 0, a read selecting peripheral i returns zero, and `periph_wr_en[i]` stays 0. After bit i is cleared, the peripheral's clock and access come back.
- R11: The power reduction bits affect `periph_clk_en` only in active and idle. In ADC noise reduction, power-down, standby and start-up, all peripheral clocks are 0 whatever the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_strobe | input | 1 | Sleep instruction strobe, one cycle |
| sleep_en | input | 1 | Sleep enable bit |
| mode_sel | input | 3 | Requested sleep mode code |
| adc_enabled | input | 1 | ADC is enabled, so sleep entry starts a conversion |
| wake_int0 | input | 1 | Level wake request from external interrupt 0 |
| wake_pcint | input | 1 | Pin-change wake request |
| wake_wdt | input | 1 | Watchdog wake request |
| wake_other | input | 1 | Wake request from any other interrupt source |
| startup_cycles | input | CNT_W | Oscillator start-up length minus one |
| prr_wr | input | 1 | Power reduction register write strobe |
| prr_wdata | input | NUM_PERIPH | Power reduction register write data |
| bus_sel | input | NUM_PERIPH | One-hot peripheral select for register access |
| bus_wr | input | 1 | Register write request |
| periph_rdata | input | NUM_PERIPH*DATA_W | Read data from each peripheral, peripheral 0 in the low slice |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_nvm | output | 1 | Non-volatile memory clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| osc_run | output | 1 | Oscillator run enable |
| adc_start | output | 1 | Start-conversion pulse to the ADC |
| mode_status | output | 3 | 0 active, 1 idle, 2 ADC noise reduction, 3 power-down, 4 standby, 5 start-up |
| wake_ack | output | 1 | One-cycle pulse on return to active |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enable |
| periph_wr_en | output | NUM_PERIPH | Per-peripheral register write enable |
| bus_rdata | output | DATA_W | Read data from the selected peripheral, or zero |

## Verification
The bench builds the block with NUM_PERIPH=3, DATA_W=8 and CNT_W=4. A 4-bit start-up counter lets the bench reach both ends of the start-up range: 0 gives a single start-up cycle, and the maximum of 15 gives sixteen. Three peripherals are enough to show one gated peripheral sitting between two live ones, so a wrong bit index or a wrong read-data slice shows up.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  // Status codes double as state encoding; mode_status exposes them directly.
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_IDLE   = 3'd1,
    ST_ADCNR  = 3'd2,
    ST_PWRDN  = 3'd3,
    ST_STDBY  = 3'd4,
    ST_OSCUP  = 3'd5
  } pwr_state_e;

  // Mode select codes sampled with the sleep strobe.
  localparam logic [2:0] SEL_IDLE  = 3'b000;
  localparam logic [2:0] SEL_ADCNR = 3'b001;
  localparam logic [2:0] SEL_PWRDN = 3'b010;
  localparam logic [2:0] SEL_STDBY = 3'b100;

  typedef struct packed {
    logic cpu;
    logic io;
    logic nvm;
    logic adc;
    logic osc;
  } clk_en_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_sleep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_strobe,
  input  logic             sleep_en,
  input  logic [2:0]       mode_sel,
  input  logic             adc_enabled,
  input  logic             wake_int0,
  input  logic             wake_pcint,
  input  logic             wake_wdt,
  input  logic             wake_other,
  input  logic [CNT_W-1:0] startup_cycles,
  output pwr_state_e       state,
  output logic             adc_start,
  output logic             wake_ack
);

  pwr_state_e       state_q, state_d, target;
  logic             sel_ok;
  logic             enter;
  logic             deep_wake, any_wake;
  logic [CNT_W-1:0] cnt_q;

  // Decode the requested mode; reserved codes are rejected.
  always_comb begin
    sel_ok = 1'b1;
    target = ST_ACTIVE;
    case (mode_sel)
      SEL_IDLE:  target = ST_IDLE;
      SEL_ADCNR: target = ST_ADCNR;
      SEL_PWRDN: target = ST_PWRDN;
      SEL_STDBY: target = ST_STDBY;
      default:   sel_ok = 1'b0;
    endcase
  end

  assign enter     = (state_q == ST_ACTIVE) && sleep_strobe && sleep_en && sel_ok;
  assign deep_wake = wake_int0 | wake_pcint | wake_wdt;
  assign any_wake  = deep_wake | wake_other;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE: if (enter)           state_d = target;
      ST_IDLE,
      ST_ADCNR:  if (any_wake)        state_d = ST_ACTIVE;
      ST_PWRDN:  if (deep_wake)       state_d = ST_OSCUP;
      ST_STDBY:  if (deep_wake)       state_d = ST_ACTIVE;
      ST_OSCUP:  if (cnt_q == '0)     state_d = ST_ACTIVE;
      default:                        state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ACTIVE;
      cnt_q     <= '0;
      adc_start <= 1'b0;
      wake_ack  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PWRDN && deep_wake) begin
        cnt_q <= startup_cycles;
      end else if (state_q == ST_OSCUP && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      adc_start <= enter && adc_enabled &&
                   (target == ST_IDLE || target == ST_ADCNR);
      wake_ack  <= (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
  import pwr_sleep_pkg::*;
(
  input  pwr_state_e state,
  output clk_en_t    en
);

  always_comb begin
    en.cpu = 1'b1;
    en.io  = 1'b1;
    en.nvm = 1'b1;
    en.adc = 1'b1;
    en.osc = 1'b1;
    case (state)
      ST_IDLE: begin
        en.cpu = 1'b0;
        en.nvm = 1'b0;
      end
      ST_ADCNR: begin
        en.cpu = 1'b0;
        en.io  = 1'b0;
        en.nvm = 1'b0;
      end
      ST_PWRDN: begin
        en.cpu = 1'b0;
        en.io  = 1'b0;
        en.nvm = 1'b0;
        en.adc = 1'b0;
        en.osc = 1'b0;
      end
      ST_STDBY, ST_OSCUP: begin
        en.cpu = 1'b0;
        en.io  = 1'b0;
        en.nvm = 1'b0;
        en.adc = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_periph_gate.sv
module pwr_periph_gate #(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         io_run,
  input  logic                         prr_wr,
  input  logic [NUM_PERIPH-1:0]        prr_wdata,
  input  logic [NUM_PERIPH-1:0]        bus_sel,
  input  logic                         bus_wr,
  input  logic [NUM_PERIPH*DATA_W-1:0] periph_rdata,
  output logic [NUM_PERIPH-1:0]        periph_clk_en,
  output logic [NUM_PERIPH-1:0]        periph_wr_en,
  output logic [DATA_W-1:0]            bus_rdata
);

  logic [NUM_PERIPH-1:0] prr_q;
  logic [DATA_W-1:0]     slice_rd [NUM_PERIPH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prr_q <= '0;
    else if (prr_wr) prr_q <= prr_wdata;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
    assign periph_clk_en[i] = io_run & ~prr_q[i];
    assign periph_wr_en[i]  = bus_wr & bus_sel[i] & periph_clk_en[i];
    assign slice_rd[i] = (bus_sel[i] && periph_clk_en[i]) ?
                         periph_rdata[i*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PERIPH; i++) bus_rdata = bus_rdata | slice_rd[i];
  end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sleep_strobe,
  input  logic                         sleep_en,
  input  logic [2:0]                   mode_sel,
  input  logic                         adc_enabled,
  input  logic                         wake_int0,
  input  logic                         wake_pcint,
  input  logic                         wake_wdt,
  input  logic                         wake_other,
  input  logic [CNT_W-1:0]             startup_cycles,
  input  logic                         prr_wr,
  input  logic [NUM_PERIPH-1:0]        prr_wdata,
  input  logic [NUM_PERIPH-1:0]        bus_sel,
  input  logic                         bus_wr,
  input  logic [NUM_PERIPH*DATA_W-1:0] periph_rdata,
  output logic                         clk_en_cpu,
  output logic                         clk_en_io,
  output logic                         clk_en_nvm,
  output logic                         clk_en_adc,
  output logic                         osc_run,
  output logic                         adc_start,
  output logic [2:0]                   mode_status,
  output logic                         wake_ack,
  output logic [NUM_PERIPH-1:0]        periph_clk_en,
  output logic [NUM_PERIPH-1:0]        periph_wr_en,
  output logic [DATA_W-1:0]            bus_rdata
);

  pwr_state_e state;
  clk_en_t    en;

  pwr_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_strobe   (sleep_strobe),
    .sleep_en       (sleep_en),
    .mode_sel       (mode_sel),
    .adc_enabled    (adc_enabled),
    .wake_int0      (wake_int0),
    .wake_pcint     (wake_pcint),
    .wake_wdt       (wake_wdt),
    .wake_other     (wake_other),
    .startup_cycles (startup_cycles),
    .state          (state),
    .adc_start      (adc_start),
    .wake_ack       (wake_ack)
  );

  pwr_clk_decode u_dec (
    .state (state),
    .en    (en)
  );

  pwr_periph_gate #(.NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_run        (en.io),
    .prr_wr        (prr_wr),
    .prr_wdata     (prr_wdata),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .periph_rdata  (periph_rdata),
    .periph_clk_en (periph_clk_en),
    .periph_wr_en  (periph_wr_en),
    .bus_rdata     (bus_rdata)
  );

  assign clk_en_cpu  = en.cpu;
  assign clk_en_io   = en.io;
  assign clk_en_nvm  = en.nvm;
  assign clk_en_adc  = en.adc;
  assign osc_run     = en.osc;
  assign mode_status = state;

endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sleep_strobe,
  input logic                  sleep_en,
  input logic                  clk_en_cpu,
  input logic                  clk_en_io,
  input logic                  clk_en_nvm,
  input logic                  clk_en_adc,
  input logic                  osc_run,
  input logic                  adc_start,
  input logic [2:0]            mode_status,
  input logic                  wake_ack,
  input logic [NUM_PERIPH-1:0] periph_clk_en,
  input logic [NUM_PERIPH-1:0] periph_wr_en
);

  assert_disabled_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd0 && sleep_strobe && !sleep_en) |=> (mode_status == 3'd0));

  assert_idle_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd1) |-> (!clk_en_cpu && !clk_en_nvm && clk_en_io && clk_en_adc));

  assert_adcnr_clocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd2) |-> (!clk_en_cpu && !clk_en_io && !clk_en_nvm && clk_en_adc));

  assert_adc_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_adc_start_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (mode_status == 3'd1 || mode_status == 3'd2));

  assert_pwrdn_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd3) |-> (!osc_run && !clk_en_adc && !clk_en_cpu));

  assert_stdby_osc_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd4) |-> (osc_run && !clk_en_io && !clk_en_adc));

  assert_startup_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 3'd5) |-> (osc_run && !clk_en_cpu && !clk_en_io));

  assert_wake_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (mode_status == 3'd0 && $past(mode_status) != 3'd0));

  assert_write_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_wr_en & ~periph_clk_en) == '0));

  assert_sleep_periph_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status >= 3'd2) |-> (periph_clk_en == '0));

endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_strobe  (sleep_strobe),
  .sleep_en      (sleep_en),
  .clk_en_cpu    (clk_en_cpu),
  .clk_en_io     (clk_en_io),
  .clk_en_nvm    (clk_en_nvm),
  .clk_en_adc    (clk_en_adc),
  .osc_run       (osc_run),
  .adc_start     (adc_start),
  .mode_status   (mode_status),
  .wake_ack      (wake_ack),
  .periph_clk_en (periph_clk_en),
  .periph_wr_en  (periph_wr_en)
);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;

  localparam int NP = 3;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_strobe = 1'b0, sleep_en = 1'b0;
  logic [2:0]    mode_sel = 3'b000;
  logic          adc_enabled = 1'b0;
  logic          wake_int0 = 1'b0, wake_pcint = 1'b0, wake_wdt = 1'b0, wake_other = 1'b0;
  logic [CW-1:0] startup_cycles = '0;
  logic          prr_wr = 1'b0;
  logic [NP-1:0] prr_wdata = '0;
  logic [NP-1:0] bus_sel = '0;
  logic          bus_wr = 1'b0;
  logic [NP*DW-1:0] periph_rdata = {8'hC3, 8'h5A, 8'hA5};
  logic          clk_en_cpu, clk_en_io, clk_en_nvm, clk_en_adc, osc_run;
  logic          adc_start, wake_ack;
  logic [2:0]    mode_status;
  logic [NP-1:0] periph_clk_en, periph_wr_en;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [NP-1:0] prr_model = '0;

  logic [12:0] q_exp [$];
  string       q_req [$];

  always #10 clk = ~clk;

  pwr_sleep_ctrl #(.NUM_PERIPH(NP), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .sleep_en(sleep_en),
    .mode_sel(mode_sel), .adc_enabled(adc_enabled), .wake_int0(wake_int0),
    .wake_pcint(wake_pcint), .wake_wdt(wake_wdt), .wake_other(wake_other),
    .startup_cycles(startup_cycles), .prr_wr(prr_wr), .prr_wdata(prr_wdata),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .periph_rdata(periph_rdata),
    .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io), .clk_en_nvm(clk_en_nvm),
    .clk_en_adc(clk_en_adc), .osc_run(osc_run), .adc_start(adc_start),
    .mode_status(mode_status), .wake_ack(wake_ack), .periph_clk_en(periph_clk_en),
    .periph_wr_en(periph_wr_en), .bus_rdata(bus_rdata)
  );

  // Expected observation built from the requirement table.
  function automatic logic [12:0] exp_vec(input logic [2:0] code, input logic st, input logic ack,
                                          input logic [NP-1:0] prr);
    logic [4:0]    ck;
    logic [NP-1:0] pc;
    case (code)
      3'd0:    ck = 5'b11111;
      3'd1:    ck = 5'b01011;
      3'd2:    ck = 5'b00011;
      3'd3:    ck = 5'b00000;
      default: ck = 5'b00001;
    endcase
    pc = (code <= 3'd1) ? ~prr : '0;
    return {ck, code, st, ack, pc};
  endfunction

  // Driver side: after the edge, queue what the next sample must show.
  task automatic go(input string req, input logic [2:0] code, input logic st, input logic ack);
    @(posedge clk);
    #1;
    q_exp.push_back(exp_vec(code, st, ack, prr_model));
    q_req.push_back(req);
  endtask

  // Monitor: pop and compare at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q_exp.size() > 0) begin
        logic [12:0] e, a;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        a = {clk_en_cpu, clk_en_io, clk_en_nvm, clk_en_adc, osc_run, mode_status,
             adc_start, wake_ack, periph_clk_en};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", r, a, e);
        end
      end
    end
  end

  task automatic check_bus(input string req, input logic [NP-1:0] sel, input logic wr,
                           input logic [DW-1:0] exp_rd, input logic [NP-1:0] exp_we);
    @(negedge clk);
    #2;
    bus_sel = sel;
    bus_wr  = wr;
    #1;
    checks++;
    if (bus_rdata !== exp_rd || periph_wr_en !== exp_we) begin
      fails++;
      $display("FAIL %s: actual rd=%h we=%b expected rd=%h we=%b", req, bus_rdata, periph_wr_en,
               exp_rd, exp_we);
    end
    bus_sel = '0;
    bus_wr  = 1'b0;
  endtask

  task automatic sleep_cmd(input logic [2:0] sel);
    @(negedge clk);
    mode_sel = sel;
    sleep_strobe = 1'b1;
  endtask

  task automatic release_cmd();
    @(negedge clk);
    sleep_strobe = 1'b0;
    wake_int0 = 1'b0; wake_pcint = 1'b0; wake_wdt = 1'b0; wake_other = 1'b0;
    prr_wr = 1'b0;
  endtask

  task automatic pwrdn_wake(input logic [CW-1:0] s, input string req);
    startup_cycles = s;
    sleep_cmd(3'b010);
    go("R6 power-down entry", 3'd3, 1'b0, 1'b0);
    release_cmd();
    wake_wdt = 1'b1;
    go(req, 3'd5, 1'b0, 1'b0);
    release_cmd();
    for (int k = 0; k < int'(s); k++) go(req, 3'd5, 1'b0, 1'b0);
    go({req, " exit"}, 3'd0, 1'b0, 1'b1);
    go("R9 ack single", 3'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go("R1 reset state", 3'd0, 1'b0, 1'b0);
    check_bus("R1 reset read peripheral 1", 3'b010, 1'b0, 8'h5A, 3'b000);

    // R2: strobe ignored without sleep enable, and for reserved codes
    sleep_cmd(3'b000);
    go("R2 sleep_en low", 3'd0, 1'b0, 1'b0);
    release_cmd();
    sleep_en = 1'b1;
    sleep_cmd(3'b011);
    go("R2 reserved 011", 3'd0, 1'b0, 1'b0);
    release_cmd();
    sleep_cmd(3'b111);
    go("R2 reserved 111", 3'd0, 1'b0, 1'b0);
    release_cmd();

    // R3/R5: idle with ADC enabled
    adc_enabled = 1'b1;
    sleep_cmd(3'b000);
    go("R3 idle entry R5 adc_start", 3'd1, 1'b1, 1'b0);
    release_cmd();
    go("R5 adc_start one cycle", 3'd1, 1'b0, 1'b0);
    // R10: gate peripheral 1 while idle
    @(negedge clk);
    prr_wr = 1'b1; prr_wdata = 3'b010; prr_model = 3'b010;
    go("R10 prr gate in idle", 3'd1, 1'b0, 1'b0);
    release_cmd();
    wake_other = 1'b1;
    go("R9 idle wake_other", 3'd0, 1'b0, 1'b1);
    release_cmd();
    go("R9 ack single", 3'd0, 1'b0, 1'b0);
    check_bus("R10 gated read zero", 3'b010, 1'b1, 8'h00, 3'b000);
    check_bus("R10 live neighbour read", 3'b100, 1'b1, 8'hC3, 3'b100);
    @(negedge clk);
    prr_wr = 1'b1; prr_wdata = 3'b000; prr_model = 3'b000;
    go("R10 prr clear", 3'd0, 1'b0, 1'b0);
    release_cmd();
    check_bus("R10 restored access", 3'b010, 1'b1, 8'h5A, 3'b010);

    // R4/R5: ADC noise reduction without and with ADC
    adc_enabled = 1'b0;
    sleep_cmd(3'b001);
    go("R4 adcnr entry R5 no start", 3'd2, 1'b0, 1'b0);
    release_cmd();
    wake_pcint = 1'b1;
    go("R9 adcnr wake pcint", 3'd0, 1'b0, 1'b1);
    release_cmd();
    adc_enabled = 1'b1;
    @(negedge clk);
    prr_wr = 1'b1; prr_wdata = 3'b001; prr_model = 3'b001;
    go("R10 prr set active", 3'd0, 1'b0, 1'b0);
    release_cmd();
    sleep_cmd(3'b001);
    go("R4 adcnr R5 start R11 periph off", 3'd2, 1'b1, 1'b0);
    release_cmd();
    wake_int0 = 1'b1;
    go("R9 adcnr wake int0", 3'd0, 1'b0, 1'b1);
    release_cmd();

    // R6: power-down ignores wake_other; R5 no start on deep entry
    sleep_cmd(3'b010);
    go("R6 entry R5 no start", 3'd3, 1'b0, 1'b0);
    release_cmd();
    wake_other = 1'b1;
    go("R6 wake_other ignored", 3'd3, 1'b0, 1'b0);
    release_cmd();
    wake_pcint = 1'b1;
    startup_cycles = 4'd3;
    go("R8 start-up", 3'd5, 1'b0, 1'b0);
    release_cmd();
    for (int k = 0; k < 3; k++) go("R8 start-up", 3'd5, 1'b0, 1'b0);
    go("R8 start-up done R9 ack", 3'd0, 1'b0, 1'b1);
    pwrdn_wake(4'd0, "R8 start-up zero");
    pwrdn_wake(4'd15, "R8 start-up max");

    // R7: standby keeps oscillator, ignores wake_other, wakes in one cycle
    sleep_cmd(3'b100);
    go("R7 standby entry", 3'd4, 1'b0, 1'b0);
    release_cmd();
    wake_other = 1'b1;
    go("R7 wake_other ignored", 3'd4, 1'b0, 1'b0);
    release_cmd();
    wake_int0 = 1'b1;
    go("R7 fast wake", 3'd0, 1'b0, 1'b1);
    release_cmd();
    go("R9 ack single", 3'd0, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule